// File: doc/BRIEF.md
# Convolutional Byte Interleaver

This block spreads a byte stream across twelve parallel delay lines of unequal length so that a burst of channel errors is split over many outer codewords. A commutator selects one line per accepted byte. The byte is pushed into that line, and the byte that falls out of the same line goes to the output. The commutator then steps to the next line. Line j holds j units of 17 bytes. The line with no delay always takes the first byte of each 204-byte packet, so sync bytes keep their spacing at the output.

A parameter turns the block into the matching deinterleaver. In that mode the line lengths are reversed, so line j holds (11 − j) units. A transmit instance followed by a receive instance then delays every byte by the same total amount. A start strobe sent with the first byte of a packet forces that byte onto line 0. This re-aligns the commutator to the packet grid.

Top module: `conv_byte_interleaver`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0 and out_data is 0x00.
- R2: out_valid equals the in_valid of the previous cycle. Each output byte appears one clock after the input byte that caused it was accepted.
- R3: The commutator selects line 0, 1, …, 11 for successive accepted bytes and then wraps to line 0. After reset the first accepted byte uses line 0, so the 13th accepted byte passes straight through.
- R4: An accepted byte with in_start high uses line 0 whatever the commutator held. The next accepted byte uses line 1.
- R5: In interleave mode (DEINT=0), line j delays its bytes by j·17 pushes of that line. Line 0 returns the input byte unchanged in the same acceptance.
- R6: Every delay stage clears to 0x00 on reset. Outputs read from stages not yet written since reset are 0x00.
- R7: A cycle with in_valid low pushes no line and leaves the commutator where it was.
- R8: In deinterleave mode (DEINT=1), line j holds (11 − j)·17 bytes. An interleaver followed by a deinterleaver returns input byte n at accepted position n + 2244, with 0x00 before that.
- R9: A byte entered with in_start high every 204 bytes appears at the output at those same 204-byte-spaced positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_start | input | 1 | Marks the first byte of a packet; forces line 0 |
| in_data | input | WIDTH | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | WIDTH | Output byte |

## Verification
A start strobe and the natural wrap of the commutator can both fall on the same accepted byte. A strobe can also arrive mid-cycle of the commutator and compete with its normal advance. The bench provokes both cases. It runs sync-marked frames in which the strobe lands exactly where the commutator would have wrapped anyway. It also strobes after seven bytes, so the advance to line 7 is overridden. Each case is judged against a per-line reference model that restarts at line 0 on the strobe. Idle gaps placed between bursts also show that a quiet cycle next to a strobe moves nothing.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  localparam int unsigned CBI_BRANCHES = 12;
  localparam int unsigned CBI_UNIT     = 17;
  localparam int unsigned CBI_WIDTH    = 8;

  // Depth of one delay line; the receive side mirrors the transmit side.
  function automatic int unsigned branch_depth(input int unsigned idx,
                                               input int unsigned branches,
                                               input int unsigned unit,
                                               input bit deint);
    return deint ? (branches - 1 - idx) * unit : idx * unit;
  endfunction
endpackage

// File: rtl/cbi_commutator.sv
module cbi_commutator #(
  parameter int unsigned BRANCHES = 12,
  parameter int unsigned SELW     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            start,
  output logic [SELW-1:0] cur
);
  localparam logic [SELW-1:0] LAST = SELW'(BRANCHES - 1);
  localparam logic [SELW-1:0] NEXT_AFTER_START = SELW'(1 % BRANCHES);

  logic [SELW-1:0] sel_q;

  assign cur = start ? '0 : sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (step) begin
      sel_q <= (cur == LAST) ? '0 : cur + 1'b1;
    end
  end

  assert_sel_range_R3: assert property (@(posedge clk) disable iff (rst)
    sel_q <= LAST);
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !start && sel_q == LAST) |=> (sel_q == '0));
  assert_start_realign_R4: assert property (@(posedge clk) disable iff (rst)
    (step && start) |=> (sel_q == NEXT_AFTER_START));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sel_q));
endmodule

// File: rtl/cbi_branch.sv
module cbi_branch #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      logic unused_pass;
      assign unused_pass = ^{clk, rst, en};
      assign dout = din;
    end else begin : g_line
      logic [WIDTH-1:0] stage [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < int'(DEPTH); k++) stage[k] <= '0;
        end else if (en) begin
          stage[0] <= din;
          for (int k = 1; k < int'(DEPTH); k++) stage[k] <= stage[k-1];
        end
      end

      assign dout = stage[DEPTH-1];

      assert_line_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout));
    end
  endgenerate
endmodule

// File: rtl/conv_byte_interleaver.sv
module conv_byte_interleaver #(
  parameter int unsigned BRANCHES = cbi_pkg::CBI_BRANCHES,
  parameter int unsigned UNIT     = cbi_pkg::CBI_UNIT,
  parameter int unsigned WIDTH    = cbi_pkg::CBI_WIDTH,
  parameter bit          DEINT    = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  localparam int unsigned SELW = (BRANCHES > 1) ? $clog2(BRANCHES) : 1;

  logic [SELW-1:0]  cur;
  logic [WIDTH-1:0] line_out [BRANCHES];

  cbi_commutator #(.BRANCHES(BRANCHES), .SELW(SELW)) u_comm (
    .clk   (clk),
    .rst   (rst),
    .step  (in_valid),
    .start (in_start),
    .cur   (cur)
  );

  for (genvar j = 0; j < int'(BRANCHES); j++) begin : g_lines
    localparam int unsigned D = cbi_pkg::branch_depth(j, BRANCHES, UNIT, DEINT);
    cbi_branch #(.WIDTH(WIDTH), .DEPTH(D)) u_line (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid && (cur == SELW'(j))),
      .din  (in_data),
      .dout (line_out[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= line_out[cur];
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  generate
    if (!DEINT) begin : g_tx_chk
      assert_line0_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cur == '0) |=> (out_data == $past(in_data)));
    end
  endgenerate
endmodule

// File: tb/conv_byte_interleaver_tb_top.sv
module conv_byte_interleaver_tb_top;
  localparam int CLK_NS = 20;
  localparam int TOTAL_DELAY = 2244;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_start = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid, rx_valid;
  logic [7:0] out_data, rx_data;

  int checks = 0, errors = 0;
  logic [7:0] mdl [12][187];
  int mbr = 0;
  bit chk_rx = 0;
  int rx_cnt = 0;

  always #(CLK_NS/2) clk = ~clk;

  conv_byte_interleaver #(.DEINT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  conv_byte_interleaver #(.DEINT(1'b1)) dut_rx (
    .clk(clk), .rst(rst), .in_valid(out_valid), .in_start(1'b0),
    .in_data(out_data), .out_valid(rx_valid), .out_data(rx_data));

  function automatic logic [7:0] pat(input int n);
    return 8'((n * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_push(input logic [7:0] d, input bit s, output logic [7:0] e);
    int dep;
    if (s) mbr = 0;
    dep = mbr * 17;
    if (dep == 0) e = d;
    else begin
      e = mdl[mbr][dep-1];
      for (int k = dep - 1; k > 0; k--) mdl[mbr][k] = mdl[mbr][k-1];
      mdl[mbr][0] = d;
    end
    mbr = (mbr + 1) % 12;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 0; in_start = 0;
    for (int b = 0; b < 12; b++) for (int k = 0; k < 187; k++) mdl[b][k] = '0;
    mbr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input bit s, input string tag, output logic [7:0] got);
    logic [7:0] e;
    in_valid = 1'b1; in_start = s; in_data = d;
    model_push(d, s, e);
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0;
    chk(out_valid == 1'b1, "R2 valid", int'(out_valid), 1);
    chk(out_data == e, tag, int'(out_data), int'(e));
    got = out_data;
  endtask

  always @(negedge clk) begin
    if (chk_rx && rx_valid) begin
      logic [7:0] e;
      e = (rx_cnt >= TOTAL_DELAY) ? pat(rx_cnt - TOTAL_DELAY) : 8'h00;
      chk(rx_data == e, "R8 cascade", int'(rx_data), int'(e));
      rx_cnt++;
    end
  end

  task automatic t_reset();
    do_reset();
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(out_data == 8'h00, "R1 out_data", int'(out_data), 0);
  endtask

  task automatic t_fill();
    logic [7:0] g;
    do_reset();
    for (int n = 0; n < 260; n++) push(pat(n), n == 0, "R5 R6 fill", g);
  endtask

  task automatic t_wrap();
    logic [7:0] g;
    do_reset();
    for (int n = 0; n < 12; n++) push(pat(n + 5), 1'b0, "R3 step", g);
    push(8'hA5, 1'b0, "R3 model", g);
    chk(g == 8'hA5, "R3 wrap to line0", int'(g), 8'hA5);
  endtask

  task automatic t_idle();
    logic [7:0] g;
    do_reset();
    for (int n = 0; n < 30; n++) push(pat(n), n == 0, "R7 pre", g);
    repeat (5) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 idle", int'(out_valid), 0);
    end
    for (int n = 30; n < 330; n++) push(pat(n), 1'b0, "R7 after idle", g);
  endtask

  task automatic t_resync();
    logic [7:0] g;
    do_reset();
    for (int n = 0; n < 7; n++) push(pat(n), 1'b0, "R4 pre", g);
    push(8'h3C, 1'b1, "R4 model", g);
    chk(g == 8'h3C, "R4 start forces line0", int'(g), 8'h3C);
    for (int n = 0; n < 250; n++) push(pat(n + 100), 1'b0, "R4 after", g);
  endtask

  task automatic t_sync();
    logic [7:0] g, d;
    do_reset();
    for (int n = 0; n < 3 * 204; n++) begin
      d = (n % 204 == 0) ? 8'h47 : ((pat(n) == 8'h47) ? 8'h48 : pat(n));
      push(d, n % 204 == 0, "R9 model", g);
      if (n % 204 == 0) chk(g == 8'h47, "R9 sync position", int'(g), 8'h47);
    end
  endtask

  task automatic t_chain();
    logic [7:0] g;
    do_reset();
    rx_cnt = 0;
    chk_rx = 1;
    for (int n = 0; n < TOTAL_DELAY + 240; n++) push(pat(n), n == 0, "R5 chain tx", g);
    repeat (3) @(negedge clk);
    chk_rx = 0;
    chk(rx_cnt == TOTAL_DELAY + 240, "R8 rx count", rx_cnt, TOTAL_DELAY + 240);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_wrap();
    t_idle();
    t_resync();
    t_sync();
    t_chain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule